// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block holds the software-visible control state for a set of general-purpose pins. Software reaches it through a single-cycle 32-bit register port with word addresses. For each pin it stores a 3-bit function code, which sets the output enable and is also exported so that an outside mux can route alternate peripherals. It also stores one output latch bit and one 2-bit pull mode per pin. Incoming pin levels pass through a two-flop synchronizer and can be read back in 32-pin banks.

Output latches change only through dedicated set and clear words, so no read-modify-write is needed. Pull modes follow a two-step protocol. Software first places a mode in one shared control word. It then writes a pin mask to the clock word of a bank, and every masked pin captures the mode at that moment. After the capture, software can return both words to zero without disturbing the captured modes.

Top module: `gpio_pin_bank`

## Requirements
- R1: Word `r` (word address `r`, 0..5) holds the function codes of pins `10r`..`10r+9`, pin `p` at bits `3*(p mod 10)+2 : 3*(p mod 10)`. Bits without a pin (bits 30..31 of each word, bits 12..31 of word 5) read zero and ignore writes. `pin_func_o[3p+2:3p]` carries the code of pin `p`.
- R2: Output enable of pin `p` is 1 only when its code is 001 (output). Code 000 (input) and the alternate codes 100, 101, 110, 111, 011 and 010 (alternate 0..5) give 0.
- R3: Writing word 7 (pins 0..31) or word 8 (pins 32..53) sets the output latch of each pin whose bit is 1 and leaves all other pins unchanged. Latches change only through words 7, 8, 10 and 11.
- R4: Writing word 10 (pins 0..31) or word 11 (pins 32..53) clears the output latch of each pin whose bit is 1 and leaves all other pins unchanged.
- R5: Set and clear words always read zero. Bits 22..31 of the bank-1 words (8, 11) have no effect.
- R6: Word 13 (pins 0..31) and word 14 (pins 32..53, bit `p-32`) return the pin inputs through a two-flop synchronizer: a change on `pin_i` is readable two clock edges later, not one. Unused bank-1 bits read zero.
- R7: Word 37 is the pull control word. Bits 1:0 hold the mode (00 none, 01 pull-down, 10 pull-up), and the upper bits read zero.
- R8: Writing word 38 (pins 0..31) or word 39 (pins 32..53, bit `p-32`) loads the current pull control value into the pull latch `pin_pull_o[2p+1:2p]` of each pin whose bit is 1. The written mask reads back from the same word, with unused bits read as zero.
- R9: A pin keeps its pull mode when its bit is 0 in a clock-word write. It also keeps it when only the control word changes. Zeroing the control word and then the clock word after a load leaves the loaded modes in place.
- R10: After reset, all function codes, output latches, pull modes, pull words and synchronizer stages are zero.
- R11: Reads are combinational from the stored state. A write is visible on a read of the same word from the next cycle, and a read in the write cycle returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pin_i | input | 54 | Pin input levels |
| pin_out_o | output | 54 | Output latch per pin |
| pin_oe_o | output | 54 | Output enable per pin |
| pin_func_o | output | 162 | Function code per pin, 3 bits each |
| pin_pull_o | output | 108 | Pull mode per pin, 2 bits each |

## Verification
A register write and a read of the same word can share a cycle, because the port carries one address for both. The bench holds the write strobe and the address of a function word across one edge and samples `rdata_o` before that edge, where it must show the old code. It samples again one cycle later, where it must show the new code. A second collision comes from the pull protocol: the control word goes back to zero while the clock word still holds the mask. The bench then checks that the captured pull mode survives.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DW        = 32;
  localparam int FW        = 3;
  localparam int PER_FSEL  = 10;
  localparam int PW        = 2;
  // word addresses
  localparam int FSEL_BASE = 0;
  localparam int SET_BASE  = 7;
  localparam int CLR_BASE  = 10;
  localparam int LEV_BASE  = 13;
  localparam int PCTL_ADDR = 37;
  localparam int PCLK_BASE = 38;

  typedef enum logic [FW-1:0] {
    FN_IN   = 3'b000,
    FN_OUT  = 3'b001,
    FN_ALT0 = 3'b100,
    FN_ALT1 = 3'b101,
    FN_ALT2 = 3'b110,
    FN_ALT3 = 3'b111,
    FN_ALT4 = 3'b011,
    FN_ALT5 = 3'b010
  } func_e;

  function automatic int lane_pins(int total, int base, int width);
    int rem;
    rem = total - base;
    return (rem < width) ? rem : width;
  endfunction
endpackage

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 6,
  localparam int NUM_REGS = (NUM_PINS + PER_FSEL - 1) / PER_FSEL
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [PER_FSEL*FW-1:0] wdata_i,
  output logic [NUM_PINS*FW-1:0] func_o,
  output logic [NUM_REGS*DW-1:0] rd_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam int NP = lane_pins(NUM_PINS, r * PER_FSEL, PER_FSEL);
    localparam int NB = NP * FW;
    logic [NB-1:0] code_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        code_q <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(FSEL_BASE + r))
        code_q <= wdata_i[NB-1:0];
    end
    assign func_o[r*PER_FSEL*FW +: NB] = code_q;
    assign rd_o[r*DW +: DW]            = DW'(code_q);
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  localparam int NUM_BANKS = (NUM_PINS + DW - 1) / DW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] set_we_i,
  input  logic [NUM_BANKS-1:0] clr_we_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [NUM_PINS-1:0]  out_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W = lane_pins(NUM_PINS, b * DW, DW);
    logic [W-1:0] lat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            lat_q <= '0;
      else if (set_we_i[b])   lat_q <= lat_q | wdata_i[W-1:0];
      else if (clr_we_i[b])   lat_q <= lat_q & ~wdata_i[W-1:0];
    end
    assign out_o[b*DW +: W] = lat_q;
  end
endmodule

// File: rtl/gpio_pull_latch.sv
module gpio_pull_latch
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  localparam int NUM_BANKS = (NUM_PINS + DW - 1) / DW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ctrl_we_i,
  input  logic [NUM_BANKS-1:0]   gate_we_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [PW-1:0]          ctrl_o,
  output logic [NUM_PINS-1:0]    gate_o,
  output logic [NUM_PINS*PW-1:0] pull_o
);
  logic [PW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= wdata_i[PW-1:0];
  end
  assign ctrl_o = ctrl_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gate
    localparam int W = lane_pins(NUM_PINS, b * DW, DW);
    logic [W-1:0] gate_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           gate_q <= '0;
      else if (gate_we_i[b]) gate_q <= wdata_i[W-1:0];
    end
    assign gate_o[b*DW +: W] = gate_q;
  end

  // capture happens on the clock-word write, so clearing control afterwards is harmless
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [PW-1:0] mode_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mode_q <= '0;
      else if (gate_we_i[p / DW] && wdata_i[p % DW])
        mode_q <= ctrl_q;
    end
    assign pull_o[p*PW +: PW] = mode_q;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 54
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] lvl_o
);
  logic [NUM_PINS-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end
  assign lvl_o = s2_q;
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 6,
  localparam int NUM_BANKS = (NUM_PINS + DW - 1) / DW,
  localparam int NUM_FSEL  = (NUM_PINS + PER_FSEL - 1) / PER_FSEL
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  input  logic [NUM_PINS-1:0]    pin_i,
  output logic [NUM_PINS-1:0]    pin_out_o,
  output logic [NUM_PINS-1:0]    pin_oe_o,
  output logic [NUM_PINS*FW-1:0] pin_func_o,
  output logic [NUM_PINS*PW-1:0] pin_pull_o
);
  logic [NUM_BANKS-1:0]   set_we, clr_we, gate_we;
  logic                   ctrl_we;
  logic [NUM_FSEL*DW-1:0] fsel_rd;
  logic [NUM_PINS-1:0]    lvl, gate;
  logic [PW-1:0]          ctrl;
  logic [DW-1:0]          lev_word  [NUM_BANKS];
  logic [DW-1:0]          gate_word [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    localparam int W = lane_pins(NUM_PINS, b * DW, DW);
    assign set_we[b]    = wr_en_i && addr_i == ADDR_W'(SET_BASE + b);
    assign clr_we[b]    = wr_en_i && addr_i == ADDR_W'(CLR_BASE + b);
    assign gate_we[b]   = wr_en_i && addr_i == ADDR_W'(PCLK_BASE + b);
    assign lev_word[b]  = DW'(lvl[b*DW +: W]);
    assign gate_word[b] = DW'(gate[b*DW +: W]);
  end
  assign ctrl_we = wr_en_i && addr_i == ADDR_W'(PCTL_ADDR);

  gpio_fsel_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_fsel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i[PER_FSEL*FW-1:0]),
    .func_o  (pin_func_o),
    .rd_o    (fsel_rd)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS)) i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (set_we),
    .clr_we_i (clr_we),
    .wdata_i  (wdata_i),
    .out_o    (pin_out_o)
  );

  gpio_pull_latch #(.NUM_PINS(NUM_PINS)) i_pull (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .gate_we_i (gate_we),
    .wdata_i   (wdata_i),
    .ctrl_o    (ctrl),
    .gate_o    (gate),
    .pull_o    (pin_pull_o)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (lvl)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assign pin_oe_o[p] = (pin_func_o[p*FW +: FW] == FN_OUT);
  end

  // set/clear words fall through to zero
  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_FSEL; r++)
      if (addr_i == ADDR_W'(FSEL_BASE + r)) rdata_o = fsel_rd[r*DW +: DW];
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == ADDR_W'(LEV_BASE + b))  rdata_o = lev_word[b];
      if (addr_i == ADDR_W'(PCLK_BASE + b)) rdata_o = gate_word[b];
    end
    if (addr_i == ADDR_W'(PCTL_ADDR)) rdata_o = DW'(ctrl);
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [DW-1:0]          wdata_i,
  input logic [DW-1:0]          rdata_o,
  input logic [NUM_PINS-1:0]    pin_out_o,
  input logic [NUM_PINS*PW-1:0] pin_pull_o
);
  logic out_word, gate_word;
  assign out_word  = addr_i == ADDR_W'(SET_BASE) || addr_i == ADDR_W'(SET_BASE + 1) ||
                     addr_i == ADDR_W'(CLR_BASE) || addr_i == ADDR_W'(CLR_BASE + 1);
  assign gate_word = addr_i == ADDR_W'(PCLK_BASE) || addr_i == ADDR_W'(PCLK_BASE + 1);

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(SET_BASE)) |=>
      pin_out_o[DW-1:0] == ($past(pin_out_o[DW-1:0]) | $past(wdata_i)));

  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(CLR_BASE)) |=>
      pin_out_o[DW-1:0] == ($past(pin_out_o[DW-1:0]) & ~$past(wdata_i)));

  p_out_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && out_word) |=> $stable(pin_out_o));

  p_rd_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_word |-> rdata_o == '0);

  p_pull_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && gate_word) |=> $stable(pin_pull_o));
endmodule

bind gpio_pin_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .pin_out_o  (pin_out_o),
  .pin_pull_o (pin_pull_o)
);

// File: tb/test_gpio_pin_bank.sv
module test_gpio_pin_bank;
  localparam int NP = 54;
  localparam int NV = 9;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [5:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_out_o, pin_oe_o;
  logic [NP*3-1:0] pin_func_o;
  logic [NP*2-1:0] pin_pull_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  gpio_pin_bank i_gpio_pin_bank (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .pin_i, .pin_out_o, .pin_oe_o, .pin_func_o, .pin_pull_o
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [75:0] VEC [NV] = '{
    {6'd0,  32'h0000_0249, 6'd0,  32'h0000_0249},  // R1 pins 0..3 output
    {6'd5,  32'hFFFF_FFFF, 6'd5,  32'h0000_0FFF},  // R1 short last word
    {6'd3,  32'hFFFF_FFFF, 6'd3,  32'h3FFF_FFFF},  // R1 bits 30..31 dropped
    {6'd7,  32'h0000_0005, 6'd7,  32'h0000_0000},  // R5 set reads zero
    {6'd8,  32'hFFFF_FFFF, 6'd8,  32'h0000_0000},  // R5
    {6'd37, 32'hFFFF_FFFE, 6'd37, 32'h0000_0002},  // R7 pull-up, upper zero
    {6'd39, 32'hFFFF_FFFF, 6'd39, 32'h003F_FFFF},  // R8 mask readback
    {6'd11, 32'h0000_0001, 6'd11, 32'h0000_0000},  // R4 clear pin 32
    {6'd14, 32'hFFFF_FFFF, 6'd37, 32'h0000_0002}   // R7 level word not writable
  };
  localparam string TAG [NV] = '{"R1","R1","R1","R5","R5","R7","R8","R4","R7"};

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    rd(6'd0, d);   chk("R10", 64'(d), 64'h0);
    chk("R10", 64'(pin_out_o), 64'h0);
    chk("R10", 64'(pin_oe_o), 64'h0);
    chk("R10", 64'(pin_pull_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(6'd39, d);  chk("R10", 64'(d), 64'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:70], VEC[i][69:38]);
      rd(VEC[i][37:32], d);
      chk(TAG[i], 64'(d), 64'(VEC[i][31:0]));
    end

    // R2 output enable from code 001 only; alt3 on 30..39, 50..53
    chk("R2", 64'(pin_oe_o), 64'h0000_0000_0000_000F);
    wr(6'd1, 32'h0000_0004);
    chk("R2", 64'(pin_func_o[32:30]), 64'h4);
    chk("R2", 64'(pin_oe_o[10]), 64'h0);
    chk("R1", 64'(pin_func_o[161:159]), 64'h7);

    // R3 set pins 0,2,32..53 then R4 cleared 32
    chk("R3", 64'(pin_out_o), 64'h003F_FFFE_0000_0005);
    wr(6'd10, 32'h0000_0001);
    chk("R4", 64'(pin_out_o), 64'h003F_FFFE_0000_0004);
    // R5 unused bank-1 bits
    wr(6'd11, 32'hFFC0_0000);
    chk("R5", 64'(pin_out_o), 64'h003F_FFFE_0000_0004);

    // R6 two-edge synchronizer latency
    @(negedge clk_i);
    pin_i = 54'h20_0000_0000_00A5;
    rd(6'd13, d);  chk("R6", 64'(d), 64'h0);
    @(negedge clk_i);
    rd(6'd13, d);  chk("R6", 64'(d), 64'h0);
    @(negedge clk_i);
    rd(6'd13, d);  chk("R6", 64'(d), 64'h0000_00A5);
    rd(6'd14, d);  chk("R6", 64'(d), 64'h0020_0000);

    // R8 / R9 pull latches
    chk("R8", 64'(pin_pull_o[81:80]), 64'h2);
    chk("R9", 64'(pin_pull_o[1:0]), 64'h0);
    wr(6'd37, 32'h1);
    chk("R9", 64'(pin_pull_o[81:80]), 64'h2);
    wr(6'd38, 32'h1);
    chk("R8", 64'(pin_pull_o[3:0]), 64'h1);
    chk("R9", 64'(pin_pull_o[81:80]), 64'h2);
    wr(6'd37, 32'h0);
    wr(6'd38, 32'h0);
    chk("R9", 64'(pin_pull_o[1:0]), 64'h1);
    rd(6'd38, d);  chk("R8", 64'(d), 64'h0);

    // R11 same-cycle read and write of one word
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 6'd2; wdata_i = 32'h0000_0007;
    #1;
    chk("R11", 64'(rdata_o), 64'h0);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
    chk("R11", 64'(rdata_o), 64'h7);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule